// File: doc/BRIEF.md
# Descriptor-Ring Receive DMA Channel

This block moves incoming frames from a byte-wide valid/ready stream into host memory buffers. Software describes empty buffers in a ring of 16-byte descriptors and hands them over by moving a last-valid pointer forward. The channel walks the ring from its current descriptor offset. It fetches one descriptor at a time over a simple request/response port and writes frame bytes one at a time over a write port. A frame always starts at a programmable byte offset inside its first buffer. Once the last byte of the frame has been stored, the channel writes the frame length as a little-endian 16-bit header into the first two bytes of that buffer.

A frame longer than the room left in its first buffer continues at byte 0 of the buffers of the following descriptors. Those continuation buffers carry no header. A descriptor word holds ctrl1 in bits [31:0], ctrl2 in bits [63:32], the low buffer address in bits [95:64] and the high address word in bits [127:96]. The high address word is not used. A frame may run out of posted buffers part way through. In overflow-continue mode the remaining bytes are then discarded, and the header still records the full received length. Control bits 8, 9 and 11 (direct FIFO, separate header, parity-check disable) are accepted but have no effect on the channel.

Top module: `rxd_channel`

## Requirements
- R1: After reset with the enable bit (control bit 0) low, status 0 and status 1 both read zero and `s_tready` is low.
- R2: One clock edge after the enable bit is sampled high in the disabled state, the state field (status 0 bits [31:28]) reads 2, idle wait.
- R3: The bytes of a frame are written in arrival order. The first byte goes to the first buffer address plus the frame offset taken from control bits [7:1].
- R4: The frame length is written low byte to buffer address +0 and high byte to +1, and only after every data byte of the frame has been written.
- R5: When the first buffer has been filled up to its capacity (ctrl2 bits [14:0]), the frame continues at byte 0 of the next descriptor's buffer. Continuation buffers get no header.
- R6: Status 0 bits [12:0] hold the current descriptor byte offset. It steps by 16 for each descriptor used and returns to 0 after a descriptor with the end-of-table flag (ctrl1 bit 28). The ring is empty when this offset equals `last_ptr`.
- R7: With overflow continue (control bit 10) set, a frame that finds the ring empty is consumed in full and discarded. No write is made, the error code stays 0 and the channel returns to idle wait.
- R8: With overflow continue clear, a frame that finds the ring empty gives error code 2 in status 1 bits [31:28] and state 3 (stopped). `s_tready` stays low.
- R9: A fetched descriptor whose capacity does not exceed the bytes reserved in it (the frame offset for a first buffer, zero otherwise) gives error code 1 and state 3.
- R10: A descriptor read answered with `desc_rd_err` high gives error code 4 and state 3.
- R11: Clearing the enable bit aborts any frame in progress without writing its header. One edge later the state reads 0, and the current offset and the error code read 0.
- R12: Setting control bits 8, 9 and 11 leaves the written bytes, header and status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 32 | Control: bit 0 enable, [7:1] frame offset, 8/9/11 ignored, 10 overflow continue |
| last_ptr | input | 13 | Byte offset of the first descriptor not yet posted |
| s_tdata | input | 8 | Stream data byte |
| s_tvalid | input | 1 | Stream byte valid |
| s_tlast | input | 1 | Last byte of frame |
| s_tready | output | 1 | Channel accepts a byte |
| desc_rd_req | output | 1 | Descriptor read request, held until answered |
| desc_rd_addr | output | 13 | Ring byte offset of the descriptor requested |
| desc_rd_valid | input | 1 | Descriptor read answer valid |
| desc_rd_data | input | 128 | Descriptor contents |
| desc_rd_err | input | 1 | Descriptor read failed, qualified by valid |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | 32 | Byte write address |
| wr_data | output | 8 | Byte write data |
| stat0 | output | 32 | State [31:28], current descriptor offset [12:0] |
| stat1 | output | 32 | Error code [31:28] |

## Verification
Each data byte appears on the write port one cycle after the edge at which it was accepted. The header's low and high bytes follow on the next two cycles, and the state field reads idle wait from the same edge as the high header byte. Status fields change one edge after their cause. The bench therefore samples everything on the falling edge. A scoreboard compares writes in order, so header-after-data is checked by position, not by cycle. Status is read only after idle wait has been observed plus one further falling edge, so every pending write has already been compared.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int OFF_W   = 13;  // ring byte offset width
  localparam int CAP_W   = 15;  // buffer capacity width
  localparam int RSV_W   = 7;   // frame offset width
  localparam int LEN_W   = 16;  // header length width
  localparam int ADDR_W  = 32;  // buffer address width
  localparam int DESC_W  = 128; // descriptor width
  localparam int DESC_STEP = 16;

  typedef enum logic [3:0] {
    ST_DISABLED  = 4'd0,
    ST_ACTIVE    = 4'd1,
    ST_IDLE_WAIT = 4'd2,
    ST_STOPPED   = 4'd3,
    ST_SUSP_PEND = 4'd4
  } rx_state_e;

  typedef enum logic [3:0] {
    ER_NONE       = 4'd0,
    ER_DESC_PROTO = 4'd1,
    ER_FIFO_OVF   = 4'd2,
    ER_XFER       = 4'd3,
    ER_DESC_READ  = 4'd4,
    ER_CORE       = 4'd5
  } rx_err_e;

  typedef struct packed {
    logic              en;
    logic [RSV_W-1:0]  rsv;
    logic              ovf_cont;
  } rx_ctrl_t;

  typedef struct packed {
    logic              eot;
    logic [CAP_W-1:0]  cap;
    logic [ADDR_W-1:0] addr;
  } rx_desc_t;

  function automatic rx_ctrl_t decode_ctrl(input logic en_bit,
                                           input logic [RSV_W-1:0] rsv,
                                           input logic oc_bit);
    rx_ctrl_t c;
    c.en       = en_bit;
    c.rsv      = rsv;
    c.ovf_cont = oc_bit;
    return c;
  endfunction

  function automatic rx_desc_t decode_desc(input logic eot_bit,
                                           input logic [CAP_W-1:0] cap,
                                           input logic [ADDR_W-1:0] addr);
    rx_desc_t d;
    d.eot  = eot_bit;
    d.cap  = cap;
    d.addr = addr;
    return d;
  endfunction

  function automatic logic [OFF_W-1:0] ring_next(input logic [OFF_W-1:0] cur,
                                                 input logic eot);
    return eot ? '0 : cur + OFF_W'(DESC_STEP);
  endfunction

  function automatic logic [7:0] len_byte(input logic [LEN_W-1:0] len,
                                          input logic hi);
    return hi ? len[15:8] : len[7:0];
  endfunction

  function automatic logic [31:0] pack_stat0(input rx_state_e s,
                                             input logic [OFF_W-1:0] cur);
    return {s, {(28-OFF_W){1'b0}}, cur};
  endfunction

  function automatic logic [31:0] pack_stat1(input rx_err_e e);
    return {e, 28'd0};
  endfunction
endpackage

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr
  import rxd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic             eot,
  input  logic [OFF_W-1:0] last_ptr,
  output logic [OFF_W-1:0] cur,
  output logic             empty
);
  logic [OFF_W-1:0] cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cur_q <= '0;
    else if (clr)   cur_q <= '0;
    else if (adv)   cur_q <= ring_next(cur_q, eot);
  end

  assign cur   = cur_q;
  assign empty = (cur_q == last_ptr);

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(cur_q)); // R6
endmodule

// File: rtl/rxd_desc_fetch.sv
module rxd_desc_fetch
  import rxd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  output logic              desc_rd_req,
  input  logic              desc_rd_valid,
  input  logic [DESC_W-1:0] desc_rd_data,
  input  logic              desc_rd_err,
  output logic              done,
  output logic              err,
  output rx_desc_t          desc
);
  logic busy_q;
  logic unused_desc_bits;

  always_ff @(posedge clk) begin
    if (!rst_n)                   busy_q <= 1'b0;
    else if (abort)               busy_q <= 1'b0;
    else if (start)               busy_q <= 1'b1;
    else if (busy_q && desc_rd_valid) busy_q <= 1'b0;
  end

  assign desc_rd_req = busy_q;
  assign done        = busy_q && desc_rd_valid;
  assign err         = desc_rd_err;
  assign desc        = decode_desc(desc_rd_data[28], desc_rd_data[46:32],
                                   desc_rd_data[95:64]);
  assign unused_desc_bits = ^{desc_rd_data[127:96], desc_rd_data[63:47],
                              desc_rd_data[31:29], desc_rd_data[27:0]};

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q); // R10
endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
  import rxd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  rx_ctrl_t          ctl,
  input  logic              empty,
  input  logic [7:0]        s_tdata,
  input  logic              s_tvalid,
  input  logic              s_tlast,
  output logic              s_tready,
  output logic              fetch_start,
  input  logic              fetch_done,
  input  logic              fetch_err,
  input  rx_desc_t          fetch_desc,
  output logic              ptr_adv,
  output logic              ptr_eot,
  output logic              ptr_clr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output rx_state_e         state_code,
  output rx_err_e           err_code
);
  typedef enum logic [3:0] {
    E_OFF, E_IDLE, E_CHECK, E_FETCH, E_DATA, E_DROP, E_HDR_LO, E_HDR_HI, E_STOP
  } eng_st_e;

  eng_st_e           st_q;
  rx_err_e           err_q;
  logic [ADDR_W-1:0] base_q, hdr_addr_q;
  logic [CAP_W-1:0]  cap_q, pos_q;
  logic [LEN_W-1:0]  len_q;
  logic              eot_q, first_q, hdr_q;

  // named events for the assertions
  logic              beat_w;
  logic              buf_full_w;
  logic              desc_bad_w;
  logic [CAP_W-1:0]  reserve_w;

  assign s_tready   = ctl.en && (st_q == E_DATA || st_q == E_DROP);
  assign beat_w     = s_tvalid && s_tready;
  assign buf_full_w = (pos_q + CAP_W'(1)) == cap_q;
  assign reserve_w  = first_q ? CAP_W'(ctl.rsv) : '0;
  assign desc_bad_w = fetch_desc.cap <= reserve_w;

  assign fetch_start = ctl.en && (st_q == E_CHECK) && !empty;
  assign ptr_adv     = ctl.en && (st_q == E_DATA) && beat_w && (s_tlast || buf_full_w);
  assign ptr_eot     = eot_q;
  assign ptr_clr     = !ctl.en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= E_OFF;
      err_q      <= ER_NONE;
      base_q     <= '0;
      hdr_addr_q <= '0;
      cap_q      <= '0;
      pos_q      <= '0;
      len_q      <= '0;
      eot_q      <= 1'b0;
      first_q    <= 1'b0;
      hdr_q      <= 1'b0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      wr_en <= 1'b0;
      if (!ctl.en) begin
        st_q  <= E_OFF;
        err_q <= ER_NONE;
        hdr_q <= 1'b0;
      end else begin
        case (st_q)
          E_OFF: st_q <= E_IDLE;
          E_IDLE: begin
            if (s_tvalid) begin
              st_q    <= E_CHECK;
              first_q <= 1'b1;
              hdr_q   <= 1'b0;
              len_q   <= '0;
            end
          end
          E_CHECK: begin
            if (empty) begin
              if (ctl.ovf_cont) st_q <= E_DROP;
              else begin
                st_q  <= E_STOP;
                err_q <= ER_FIFO_OVF;
              end
            end else begin
              st_q <= E_FETCH;
            end
          end
          E_FETCH: begin
            if (fetch_done) begin
              if (fetch_err) begin
                st_q  <= E_STOP;
                err_q <= ER_DESC_READ;
              end else if (desc_bad_w) begin
                st_q  <= E_STOP;
                err_q <= ER_DESC_PROTO;
              end else begin
                base_q  <= fetch_desc.addr;
                cap_q   <= fetch_desc.cap;
                eot_q   <= fetch_desc.eot;
                pos_q   <= reserve_w;
                first_q <= 1'b0;
                if (first_q) begin
                  hdr_addr_q <= fetch_desc.addr;
                  hdr_q      <= 1'b1;
                end
                st_q <= E_DATA;
              end
            end
          end
          E_DATA: begin
            if (beat_w) begin
              wr_en   <= 1'b1;
              wr_addr <= base_q + ADDR_W'(pos_q);
              wr_data <= s_tdata;
              pos_q   <= pos_q + CAP_W'(1);
              len_q   <= len_q + LEN_W'(1);
              if (s_tlast)         st_q <= E_HDR_LO;
              else if (buf_full_w) st_q <= E_CHECK;
            end
          end
          E_DROP: begin
            if (beat_w) begin
              len_q <= len_q + LEN_W'(1);
              if (s_tlast) st_q <= hdr_q ? E_HDR_LO : E_IDLE;
            end
          end
          E_HDR_LO: begin
            wr_en   <= 1'b1;
            wr_addr <= hdr_addr_q;
            wr_data <= len_byte(len_q, 1'b0);
            st_q    <= E_HDR_HI;
          end
          E_HDR_HI: begin
            wr_en   <= 1'b1;
            wr_addr <= hdr_addr_q + ADDR_W'(1);
            wr_data <= len_byte(len_q, 1'b1);
            hdr_q   <= 1'b0;
            st_q    <= E_IDLE;
          end
          E_STOP:  st_q <= E_STOP;
          default: st_q <= E_OFF;
        endcase
      end
    end
  end

  always_comb begin
    case (st_q)
      E_OFF:   state_code = ST_DISABLED;
      E_IDLE:  state_code = ST_IDLE_WAIT;
      E_STOP:  state_code = ST_STOPPED;
      default: state_code = ST_ACTIVE;
    endcase
  end
  assign err_code = err_q;

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.en |=> (state_code == ST_DISABLED)); // R11
  AST_ERR_MEANS_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != ER_NONE) |-> (state_code == ST_STOPPED)); // R8
  AST_STOPPED_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == ST_STOPPED) |-> !s_tready); // R8
  AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == E_DROP) |=> !wr_en); // R7
endmodule

// File: rtl/rxd_channel.sv
module rxd_channel
  import rxd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       ctrl_word,
  input  logic [OFF_W-1:0]  last_ptr,
  input  logic [7:0]        s_tdata,
  input  logic              s_tvalid,
  input  logic              s_tlast,
  output logic              s_tready,
  output logic              desc_rd_req,
  output logic [OFF_W-1:0]  desc_rd_addr,
  input  logic              desc_rd_valid,
  input  logic [DESC_W-1:0] desc_rd_data,
  input  logic              desc_rd_err,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic [31:0]       stat0,
  output logic [31:0]       stat1
);
  rx_ctrl_t         ctl;
  logic             unused_ctrl_bits;
  logic [OFF_W-1:0] cur;
  logic             empty;
  logic             fetch_start, fetch_done, fetch_err;
  rx_desc_t         fetch_desc;
  logic             ptr_adv, ptr_eot, ptr_clr;
  rx_state_e        state_code;
  rx_err_e          err_code;

  assign ctl = decode_ctrl(ctrl_word[0], ctrl_word[7:1], ctrl_word[10]);
  // direct FIFO, separate header and parity-disable bits are not acted on
  assign unused_ctrl_bits = ^{ctrl_word[31:11], ctrl_word[9:8]};

  rxd_ring_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(ptr_clr), .adv(ptr_adv), .eot(ptr_eot),
    .last_ptr(last_ptr), .cur(cur), .empty(empty)
  );

  rxd_desc_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .start(fetch_start), .abort(ptr_clr),
    .desc_rd_req(desc_rd_req), .desc_rd_valid(desc_rd_valid),
    .desc_rd_data(desc_rd_data), .desc_rd_err(desc_rd_err),
    .done(fetch_done), .err(fetch_err), .desc(fetch_desc)
  );

  rxd_engine u_eng (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .empty(empty),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
    .fetch_start(fetch_start), .fetch_done(fetch_done), .fetch_err(fetch_err),
    .fetch_desc(fetch_desc), .ptr_adv(ptr_adv), .ptr_eot(ptr_eot), .ptr_clr(ptr_clr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .state_code(state_code), .err_code(err_code)
  );

  assign desc_rd_addr = cur;
  assign stat0 = pack_stat0(state_code, cur);
  assign stat1 = pack_stat1(err_code);

  AST_EMPTY_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == last_ptr) |-> !fetch_start); // R6
endmodule

// File: tb/rxd_channel_test.sv
module rxd_channel_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  ctrl_word = '0;
  logic [12:0]  last_ptr = '0;
  logic [7:0]   s_tdata = '0;
  logic         s_tvalid = 1'b0;
  logic         s_tlast = 1'b0;
  logic         s_tready;
  logic         desc_rd_req;
  logic [12:0]  desc_rd_addr;
  logic         desc_rd_valid;
  logic [127:0] desc_rd_data;
  logic         desc_rd_err;
  logic         wr_en;
  logic [31:0]  wr_addr;
  logic [7:0]   wr_data;
  logic [31:0]  stat0, stat1;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  logic [39:0]  exp_q[$];
  logic [127:0] desc_mem [512];
  logic         inject = 1'b0;

  always #2.5 clk = ~clk; // 200 MHz

  rxd_channel uut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .last_ptr(last_ptr),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
    .desc_rd_req(desc_rd_req), .desc_rd_addr(desc_rd_addr),
    .desc_rd_valid(desc_rd_valid), .desc_rd_data(desc_rd_data),
    .desc_rd_err(desc_rd_err), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .stat0(stat0), .stat1(stat1)
  );

  // descriptor memory: answers one cycle after a request
  always @(posedge clk) begin
    if (!rst_n) begin
      desc_rd_valid <= 1'b0;
      desc_rd_data  <= '0;
      desc_rd_err   <= 1'b0;
    end else if (desc_rd_req && !desc_rd_valid) begin
      desc_rd_valid <= 1'b1;
      desc_rd_data  <= desc_mem[desc_rd_addr[12:4]];
      desc_rd_err   <= inject;
    end else begin
      desc_rd_valid <= 1'b0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    logic [39:0] e;
    if (rst_n && wr_en) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s unexpected write actual=%h:%h expected=none", cur_req, wr_addr, wr_data);
      end else begin
        e = exp_q.pop_front();
        if ({wr_addr, wr_data} !== e) begin
          fails++;
          $display("FAIL %s write actual=%h:%h expected=%h:%h", cur_req,
                   wr_addr, wr_data, e[39:8], e[7:0]);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed + i * 7) & 255);
  endfunction

  function automatic void set_desc(input int idx, input bit eot, input int cap,
                                   input logic [31:0] addr);
    desc_mem[idx] = {32'h0, addr, 17'h0, 15'(cap), 3'b000, eot, 28'h0};
  endfunction

  // expected writes computed from the requirements (R3, R4, R5)
  function automatic void expect_frame(input int idx0, input int off, input int len,
                                       input int seed, input bit hdr);
    int idx = idx0;
    logic [127:0] d = desc_mem[idx0];
    int cap = int'(d[46:32]);
    logic [31:0] base = d[95:64];
    logic [31:0] hdr_a = d[95:64];
    int pos = off;
    for (int i = 0; i < len; i++) begin
      if (pos == cap) begin
        idx  = d[28] ? 0 : idx + 1;
        d    = desc_mem[idx];
        cap  = int'(d[46:32]);
        base = d[95:64];
        pos  = 0;
      end
      exp_q.push_back({base + 32'(pos), pat(seed, i)});
      pos++;
    end
    if (hdr) begin
      exp_q.push_back({hdr_a, 8'(len & 255)});
      exp_q.push_back({hdr_a + 32'd1, 8'((len >> 8) & 255)});
    end
  endfunction

  task automatic send(input int len, input int seed, input bit with_last, output bit ok);
    int t;
    ok = 1'b1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      s_tvalid = 1'b1;
      s_tdata  = pat(seed, i);
      s_tlast  = with_last && (i == len - 1);
      t = 0;
      while (!s_tready && t < 200) begin
        @(negedge clk);
        t++;
      end
      if (!s_tready) begin
        ok = 1'b0;
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
        return;
      end
      @(posedge clk);
    end
    @(negedge clk);
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
  endtask

  task automatic wait_state(input logic [3:0] code);
    int t = 0;
    while (stat0[31:28] !== code && t < 500) begin
      @(negedge clk);
      t++;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    for (int i = 0; i < 512; i++) desc_mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 stat0", stat0, 32'h0);
    chk("R1 stat1", stat1, 32'h0);
    chk("R1 tready", {31'd0, s_tready}, 32'd0);

    set_desc(0, 1'b0, 64, 32'h1000);
    set_desc(1, 1'b0, 16, 32'h2000);
    set_desc(2, 1'b0, 16, 32'h3000);
    set_desc(3, 1'b1, 32, 32'h4000);

    // R2 enable -> idle wait after one edge
    cur_req = "R2";
    ctrl_word = 32'h1 | (32'd4 << 1);
    @(negedge clk);
    chk("R2 state", {28'd0, stat0[31:28]}, 32'd2);

    // R3/R4 single-buffer frame
    cur_req = "R3";
    last_ptr = 13'h30;
    expect_frame(0, 4, 20, 1, 1'b1);
    send(20, 1, 1'b1, ok);
    wait_state(4'd2);
    chk("R4 all data and header written", exp_q.size(), 32'd0);
    chk("R6 offset after one descriptor", {19'd0, stat0[12:0]}, 32'h10);

    // R5 scatter over three descriptors, R6 wrap on end-of-table
    cur_req = "R5";
    last_ptr = 13'h0;
    expect_frame(1, 4, 30, 50, 1'b1);
    send(30, 50, 1'b1, ok);
    wait_state(4'd2);
    chk("R5 scatter writes", exp_q.size(), 32'd0);
    chk("R6 wrap to 0", {19'd0, stat0[12:0]}, 32'h0);
    chk("R5 state idle", {28'd0, stat0[31:28]}, 32'd2);

    // R7 overflow continue with empty ring
    cur_req = "R7";
    ctrl_word = 32'h1 | (32'd4 << 1) | (32'd1 << 10);
    @(negedge clk);
    send(5, 3, 1'b1, ok);
    chk("R7 frame consumed", {31'd0, ok}, 32'd1);
    wait_state(4'd2);
    chk("R7 error none", stat1, 32'h0);
    chk("R7 state idle", {28'd0, stat0[31:28]}, 32'd2);
    chk("R7 offset kept", {19'd0, stat0[12:0]}, 32'h0);

    // R12 ignored control bits
    cur_req = "R12";
    ctrl_word = 32'h1 | (32'd4 << 1) | (32'd1 << 10) | (32'd1 << 8) | (32'd1 << 9) | (32'd1 << 11);
    last_ptr = 13'h10;
    expect_frame(0, 4, 3, 9, 1'b1);
    send(3, 9, 1'b1, ok);
    wait_state(4'd2);
    chk("R12 writes unchanged", exp_q.size(), 32'd0);
    chk("R12 offset", {19'd0, stat0[12:0]}, 32'h10);
    chk("R12 error none", stat1, 32'h0);

    // R8 empty ring without overflow continue
    cur_req = "R8";
    ctrl_word = 32'h1 | (32'd4 << 1);
    @(negedge clk);
    send(4, 5, 1'b1, ok);
    chk("R8 frame refused", {31'd0, ok}, 32'd0);
    chk("R8 state stopped", {28'd0, stat0[31:28]}, 32'd3);
    chk("R8 error code", stat1, 32'h2000_0000);
    chk("R8 tready low", {31'd0, s_tready}, 32'd0);

    // R11 disable clears state
    cur_req = "R11";
    ctrl_word = 32'h0;
    @(negedge clk);
    chk("R11 stat0 cleared", stat0, 32'h0);
    chk("R11 stat1 cleared", stat1, 32'h0);

    // R11 abort mid-frame: no header
    ctrl_word = 32'h1 | (32'd4 << 1);
    @(negedge clk);
    last_ptr = 13'h10;
    expect_frame(0, 4, 3, 77, 1'b0);
    send(3, 77, 1'b0, ok);
    @(negedge clk);
    ctrl_word = 32'h0;
    @(negedge clk);
    chk("R11 abort state", {28'd0, stat0[31:28]}, 32'd0);
    repeat (6) @(negedge clk);
    chk("R11 abort no header", exp_q.size(), 32'd0);
    chk("R11 abort offset", {19'd0, stat0[12:0]}, 32'h0);

    // R9 descriptor capacity not above reserve
    cur_req = "R9";
    set_desc(0, 1'b0, 4, 32'h5000);
    ctrl_word = 32'h1 | (32'd4 << 1);
    @(negedge clk);
    send(2, 11, 1'b1, ok);
    chk("R9 state stopped", {28'd0, stat0[31:28]}, 32'd3);
    chk("R9 error code", stat1, 32'h1000_0000);
    ctrl_word = 32'h0;
    @(negedge clk);

    // R10 descriptor read error
    cur_req = "R10";
    set_desc(0, 1'b0, 64, 32'h1000);
    inject = 1'b1;
    ctrl_word = 32'h1 | (32'd4 << 1);
    @(negedge clk);
    send(2, 13, 1'b1, ok);
    chk("R10 state stopped", {28'd0, stat0[31:28]}, 32'd3);
    chk("R10 error code", stat1, 32'h4000_0000);
    inject = 1'b0;
    ctrl_word = 32'h0;
    repeat (3) @(negedge clk);
    chk("R10 no stray writes", exp_q.size(), 32'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule